// File: doc/BRIEF.md
# SMBus Indexed Block-Access Register Slave

This block is a two-wire bus slave that gives a host indexed block access to a small bank of 8-bit configuration registers. Both bus lines are brought into the system clock domain, filtered, and turned into edge, START and STOP events. The slave answers only to its 7-bit device address. In a write, the host sends a starting index, a byte count and then that many data bytes. In a read, the host first sets the index in a write phase, then issues a repeated START with the read bit set. The slave then sends a count byte followed by register contents from the index upward.

The register bank sits outside the block and is reached through plain pins. A write is a one-cycle strobe that carries an address and data. The bank must accept it in that cycle, because the bus cannot be held off (there is no clock stretching). There is therefore no valid/ready pair: the bus timing sets the pace and no back-pressure exists. For reads the block presents an index and expects the bank to return the matching data combinationally in the same cycle. SDA is driven open-drain style: `sda_oe` high means the line is pulled low.

Top module: `smb_blk_slave`

## Requirements
- R1: After reset the block releases SDA (`sda_oe` = 0) and issues no register write.
- R2: The first byte after START is matched against DEV_ADDR (default 0x6A, carried in byte bits 7:1, bit 0 = 1 for a read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it never drives SDA until the next START and writes nothing.
- R3: In a write (address bit 0 = 0), the second byte sets the index N and the third byte sets the count X. Each of the next X data bytes is acknowledged and written to register N, N+1, … in turn, one `reg_we` pulse per byte.
- R4: A data byte received after the count is exhausted is not acknowledged and not written, and the slave then ignores the bus until the next START.
- R5: Data bytes aimed at an index ≥ NUM_REGS are acknowledged but produce no `reg_we` pulse.
- R6: After a read address, the slave sends first a count byte equal to NUM_REGS − N (0 when N ≥ NUM_REGS), then register N, N+1, … for as long as the host acknowledges. Bytes are sent MSB first.
- R7: A read of an index ≥ NUM_REGS returns 0xFF.
- R8: When the host does not acknowledge a transmitted byte, the slave releases SDA and drives nothing until the next START.
- R9: A STOP in the middle of any byte aborts the transfer; the partial byte is discarded and SDA is released.
- R10: A START seen in the middle of a transfer drops it and restarts address matching with the following byte.
- R11: The slave changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | 8 | Register index for the write strobe |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_raddr | output | 8 | Register index whose data is wanted for reading |
| reg_rdata | input | 8 | Combinational read data for `reg_raddr` |

## Verification
The assertions assume that SDA changes only while SCL is low, except when forming START and STOP. They also assume that every bus level lasts well beyond the synchroniser and filter delay, so that edges on the two lines are never seen in the wrong order. The bench's bus model holds each SCL quarter-phase for ten system clocks. It moves SDA only in the middle of the low phase, or in the middle of the high phase for START and STOP. The slave's reaction time after an SCL fall therefore always lands before the next point where the host samples.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } st_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_IDX,
    PH_CNT,
    PH_DATA
  } ph_t;
endpackage

// File: rtl/smb_pin_filter.sv
module smb_pin_filter #(
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  localparam int CW = $clog2(FILT + 1);

  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], pin_i};
  end

  // the level only follows after FILT consecutive disagreeing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= 1'b1;
      cnt_q <= '0;
    end else if (sync_q[SYNC-1] == lvl_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT - 1)) begin
      lvl_o <= sync_q[SYNC-1];
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       reg_we,
  output logic [7:0] reg_waddr,
  output logic [7:0] reg_wdata,
  output logic [7:0] reg_raddr,
  input  logic [7:0] reg_rdata
);
  import smb_blk_pkg::*;

  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  logic scl_flt, sda_flt;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  smb_pin_filter #(.SYNC(SYNC_STAGES), .FILT(FILT_LEN)) u_scl_flt (
    .clk(clk), .rst_n(rst_n), .pin_i(scl_i), .lvl_o(scl_flt));
  smb_pin_filter #(.SYNC(SYNC_STAGES), .FILT(FILT_LEN)) u_sda_flt (
    .clk(clk), .rst_n(rst_n), .pin_i(sda_i), .lvl_o(sda_flt));

  smb_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl(scl_flt), .sda(sda_flt),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  st_t        st;
  ph_t        ph;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic [7:0] idx;
  logic [7:0] remain;
  logic       ack_drv;
  logic       tx_next;
  logic       first_tx;

  logic       in_range;
  logic [7:0] rd_byte;
  logic [7:0] rd_count;

  assign in_range  = idx < NREG8;
  assign rd_byte   = in_range ? reg_rdata : 8'hFF;
  assign rd_count  = in_range ? (NREG8 - idx) : 8'h00;
  assign reg_raddr = idx;
  assign sda_oe    = ((st == ST_ACK) && ack_drv) || ((st == ST_TX) && !sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_ADDR;
      bitcnt    <= '0;
      sh        <= '0;
      idx       <= '0;
      remain    <= '0;
      ack_drv   <= 1'b0;
      tx_next   <= 1'b0;
      first_tx  <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_ev) begin
        st     <= ST_RX;
        ph     <= PH_ADDR;
        bitcnt <= '0;
      end else if (stop_ev) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_flt};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt  <= '0;
              ack_drv <= 1'b1;
              tx_next <= 1'b0;
              unique case (ph)
                PH_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    st       <= ST_ACK;
                    tx_next  <= sh[0];
                    first_tx <= 1'b1;
                    ph       <= PH_IDX;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_IDX: begin
                  idx <= sh;
                  ph  <= PH_CNT;
                  st  <= ST_ACK;
                end
                PH_CNT: begin
                  remain <= sh;
                  ph     <= PH_DATA;
                  st     <= ST_ACK;
                end
                PH_DATA: begin
                  if (remain == 8'd0) begin
                    st <= ST_IDLE;
                  end else begin
                    remain <= remain - 1'b1;
                    st     <= ST_ACK;
                    idx    <= idx + 1'b1;
                    if (in_range) begin
                      reg_we    <= 1'b1;
                      reg_waddr <= idx;
                      reg_wdata <= sh;
                    end
                  end
                end
                default: st <= ST_IDLE;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (tx_next) begin
                st <= ST_TX;
                if (first_tx) begin
                  sh       <= rd_count;
                  first_tx <= 1'b0;
                end else begin
                  sh  <= rd_byte;
                  idx <= idx + 1'b1;
                end
              end else begin
                st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                st <= ST_RACK;
              end else begin
                sh     <= {sh[6:0], 1'b1};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_flt) begin
                st <= ST_IDLE;
              end else begin
                st      <= ST_ACK;
                ack_drv <= 1'b0;
                tx_next <= 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_blk_slave_chk.sv
module smb_blk_slave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              start_ev,
  input logic              stop_ev,
  input smb_blk_pkg::st_t  st,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [7:0]        reg_waddr
);
  import smb_blk_pkg::*;

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  a_r3_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r5_we_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_waddr < 8'(NUM_REGS)));

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE && !sda_oe));

  a_r10_start_rematch: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_RX && !sda_oe));

  a_r11_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
endmodule

bind smb_blk_slave smb_blk_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_flt), .start_ev(start_ev),
  .stop_ev(stop_ev), .st(st), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_waddr(reg_waddr));

// File: tb/smb_blk_slave_bench.sv
module smb_blk_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int NREG = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_h = 1'b1;
  logic       sda_oe, reg_we;
  logic [7:0] reg_waddr, reg_wdata, reg_raddr, reg_rdata;
  logic       sda_bus;
  logic [7:0] bank [NREG];
  logic [7:0] expb [NREG];

  int n_tests = 0, n_fail = 0;
  int we_cnt = 0, oe_cnt = 0, oe_hi_chg = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  smb_blk_slave u_smb_blk_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= 8'h10 + 8'(i);
    end else if (reg_we && reg_waddr < NREG) begin
      bank[reg_waddr[2:0]] <= reg_wdata;
    end
  end
  assign reg_rdata = (reg_raddr < NREG) ? bank[reg_raddr[2:0]] : 8'h00;

  always @(posedge clk) begin
    if (reg_we) we_cnt++;
    if (sda_oe) oe_cnt++;
    if (sda_oe != oe_prev && scl) oe_hi_chg++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    qwait(); sda_h = b; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0;
  endtask

  task automatic rbit(output logic s);
    qwait(); sda_h = 1'b1; qwait(); scl = 1'b1; qwait(); s = sda_bus; qwait(); scl = 1'b0;
  endtask

  task automatic bus_start();
    qwait(); sda_h = 1'b0; qwait(); qwait(); scl = 1'b0;
  endtask

  task automatic bus_rstart();
    qwait(); sda_h = 1'b1; qwait(); scl = 1'b1; qwait(); qwait();
    sda_h = 1'b0; qwait(); qwait(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    qwait(); sda_h = 1'b0; qwait(); scl = 1'b1; qwait(); qwait();
    sda_h = 1'b1; qwait(); qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin rbit(s); b[i] = s; end
    wbit(!ack);
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NREG; i++) chk(bank[i] == expb[i], req, bank[i], expb[i]);
  endtask

  // R1: state right after reset
  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 no write", reg_we, 0);
  endtask

  // R2 R3: multi-byte write
  task automatic t_write_multi();
    logic a;
    int w0 = we_cnt;
    bus_start();
    send_byte(8'hD4, a); chk(a, "R2 address ack", a, 1);
    send_byte(8'h02, a); chk(a, "R3 index ack", a, 1);
    send_byte(8'h03, a); chk(a, "R3 count ack", a, 1);
    send_byte(8'hA1, a); chk(a, "R3 data0 ack", a, 1);
    send_byte(8'hA2, a); chk(a, "R3 data1 ack", a, 1);
    send_byte(8'hA3, a); chk(a, "R3 data2 ack", a, 1);
    bus_stop();
    expb[2] = 8'hA1; expb[3] = 8'hA2; expb[4] = 8'hA3;
    chk(we_cnt - w0 == 3, "R3 write pulses", we_cnt - w0, 3);
    chk_bank("R3 bank contents");
  endtask

  // R6 R8: read back with count
  task automatic t_readback();
    logic a; logic [7:0] b;
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h02, a);
    bus_rstart();
    send_byte(8'hD5, a); chk(a, "R6 read address ack", a, 1);
    recv_byte(1'b1, b); chk(b == 8'h06, "R6 count byte", b, 6);
    recv_byte(1'b1, b); chk(b == 8'hA1, "R6 data0", b, 8'hA1);
    recv_byte(1'b1, b); chk(b == 8'hA2, "R6 data1", b, 8'hA2);
    recv_byte(1'b0, b); chk(b == 8'hA3, "R6 data2", b, 8'hA3);
    bus_stop();
  endtask

  // R2: foreign address
  task automatic t_mismatch();
    logic a;
    int o0;
    bus_start();
    o0 = oe_cnt;
    send_byte(8'hA4, a); chk(!a, "R2 mismatch nack", a, 0);
    send_byte(8'h00, a); send_byte(8'h01, a); send_byte(8'h77, a);
    chk(oe_cnt == o0, "R2 never drives", oe_cnt - o0, 0);
    bus_stop();
    chk_bank("R2 no write on mismatch");
  endtask

  // R4: byte past count
  task automatic t_overcount();
    logic a;
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'h5A, a); chk(a, "R4 counted byte ack", a, 1);
    send_byte(8'h5B, a); chk(!a, "R4 extra byte nack", a, 0);
    bus_stop();
    expb[0] = 8'h5A;
    chk_bank("R4 extra byte dropped");
  endtask

  // R5 R7: index beyond the bank
  task automatic t_beyond();
    logic a; logic [7:0] b;
    int w0 = we_cnt;
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h07, a); send_byte(8'h02, a);
    send_byte(8'hC7, a); chk(a, "R5 last reg ack", a, 1);
    send_byte(8'hC8, a); chk(a, "R5 out-of-range ack", a, 1);
    bus_stop();
    expb[7] = 8'hC7;
    chk(we_cnt - w0 == 1, "R5 single write", we_cnt - w0, 1);
    chk_bank("R5 bank contents");
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h07, a);
    bus_rstart();
    send_byte(8'hD5, a);
    recv_byte(1'b1, b); chk(b == 8'h01, "R6 count near end", b, 1);
    recv_byte(1'b1, b); chk(b == 8'hC7, "R7 last reg", b, 8'hC7);
    recv_byte(1'b0, b); chk(b == 8'hFF, "R7 beyond reads FF", b, 8'hFF);
    bus_stop();
  endtask

  // R9: STOP inside a data byte
  task automatic t_early_stop();
    logic a;
    int w0 = we_cnt;
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h01, a); send_byte(8'h02, a);
    send_byte(8'h3C, a);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bus_stop();
    expb[1] = 8'h3C;
    chk(we_cnt - w0 == 1, "R9 partial byte discarded", we_cnt - w0, 1);
    chk(sda_oe == 1'b0, "R9 released", sda_oe, 0);
    chk_bank("R9 bank contents");
  endtask

  // R10: START inside the address byte
  task automatic t_restart();
    logic a;
    bus_start();
    wbit(1'b1); wbit(1'b1); wbit(1'b0);
    bus_rstart();
    send_byte(8'hD4, a); chk(a, "R10 rematch ack", a, 1);
    send_byte(8'h06, a); send_byte(8'h01, a);
    send_byte(8'h66, a); chk(a, "R10 data ack", a, 1);
    bus_stop();
    expb[6] = 8'h66;
    chk_bank("R10 bank contents");
  endtask

  // R8: host NACK releases the line
  task automatic t_nack_release();
    logic a, s; logic [7:0] b;
    int o0;
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h00, a);
    bus_rstart();
    send_byte(8'hD5, a);
    recv_byte(1'b0, b); chk(b == 8'h08, "R6 full count", b, 8);
    o0 = oe_cnt;
    for (int i = 0; i < 9; i++) rbit(s);
    chk(oe_cnt == o0, "R8 silent after nack", oe_cnt - o0, 0);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) expb[i] = 8'h10 + 8'(i);
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write_multi();
    t_readback();
    t_mismatch();
    t_overcount();
    t_beyond();
    t_early_stop();
    t_restart();
    t_nack_release();
    chk(oe_hi_chg == 0, "R11 drive moves only with SCL low", oe_hi_chg, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule